// File: doc/BRIEF.md
# Sleep-Aware GPIO Pad State Controller

This block sits between the GPIO and peripheral logic and a bank of general-purpose pads. It drives each pad's output enable, output data, input enable and pull-up enable. In run mode each pin follows one of two sources. When its function-select bit is set, it follows the peripheral's enable and data. When the bit is clear, it follows the GPIO direction and data registers.

A single-cycle sleep-entry pulse takes a snapshot of a per-pin sleep configuration, and the pads hold that snapshot until a sleep-exit pulse arrives. How a pin behaves in sleep depends on the group it belongs to, which is fixed at elaboration:
- Ordinary pins drive their sleep value if they are outputs and float if they are inputs.
- Memory-control pins and card-control pins each have a float bit that sends the whole group to high impedance.
- Memory strobe pins are driven high when the memory float bit is clear.

A sticky read-disable-hold flag keeps every input buffer gated from reset onward, and again after every sleep entry, until software writes 1 to clear it. Clearing the flag also turns the pull-ups off. Sleep entry sets the flag again but leaves the pull-ups off. Four pins leave reset in their peripheral function and are returned to it on every sleep exit.

Top module: `gpio_sleep_pad_ctrl`

## Requirements
- R1: After reset, the register contents are as follows. Direction, GPIO data, sleep value and both float bits are zero. Function-select equals ALT_MASK (pins 4 to 7 by default). The hold flag and the pull-up flag are 1, so pad_ie is all 0 and pad_pu is all 1. STATUS reads 3.
- R2: A register write with STATUS bit 0 = 1 clears the hold flag and the pull-up flag. From the next cycle pad_ie is all 1 and pad_pu is all 0. A STATUS write with bit 0 = 0 changes nothing.
- R3: An accepted sleep entry sets the hold flag, so pad_ie is all 0 from the next cycle. pad_pu stays all 0 once it has been cleared.
- R4: In run mode, a pin whose function-select bit is 1 shows alt_oe/alt_out on pad_oe/pad_out. Otherwise it shows its direction bit (1 = output) and its GPIO data bit. Register writes show on the pads one cycle after the write strobe.
- R5: Each ordinary pin is set from the registers at the sleep-entry edge and stays on that setting for the whole sleep. An output drives its sleep-value bit. An input has pad_oe 0. Register writes made during sleep do not change the pads.
- R6: With CFG bit 0 (memory float) set, memory-group pins have pad_oe 0 in sleep. With it clear, the non-strobe memory pins follow R5.
- R7: With memory float clear, the strobe pins (pins 8 to 10 by default) are driven high in sleep with pad_oe 1, whatever their direction bit.
- R8: With CFG bit 1 (card float) set, card-group pins (pins 12 to 15 by default) have pad_oe 0 in sleep. With it clear, they follow R5.
- R9: On sleep exit, the function-select bits of the ALT_MASK pins are forced back to 1. All other function-select bits keep their value.
- R10: A sleep-exit pulse returns the pads to run-mode muxing from the next cycle. A sleep exit while awake and a sleep entry while asleep are both ignored.
- R11: gpio_in equals pad_in AND pad_ie.
- R12: When reg_rd is high, reg_rdata shows the register at reg_addr, in the same cycle: 0 DIR, 1 DOUT, 2 AFSEL, 3 SLPVAL, 4 CFG {card float, memory float}, 5 STATUS {asleep, pull-up, hold} in bits 2..0. When reg_rd is low, reg_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_enter | input | 1 | One-cycle sleep entry pulse |
| sleep_exit | input | 1 | One-cycle sleep exit pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | NUM_PINS | Write data |
| reg_rdata | output | NUM_PINS | Read data |
| alt_oe | input | NUM_PINS | Peripheral output enables |
| alt_out | input | NUM_PINS | Peripheral output data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| gpio_in | output | NUM_PINS | Gated input data |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_out | output | NUM_PINS | Pad output data |
| pad_ie | output | NUM_PINS | Pad input buffer enable |
| pad_pu | output | NUM_PINS | Pad pull-up enable |
| asleep | output | 1 | Sleep state held |

## Verification
Three kinds of result appear at different times:
- Register writes, sleep entry and sleep exit are each registered once, so their effect shows on the pads in the cycle after the strobe's edge.
- Read data and gpio_in are combinational.
- Changes on alt_oe/alt_out reach the pads within the same cycle.

The bench drives every stimulus on the falling edge and lets one rising edge pass. It then samples on the next falling edge for the registered results. For the combinational results it samples a short delay after driving, within the same low phase.

// File: rtl/gspc_pkg.sv
package gspc_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_DIR    = 3'd0;
    localparam logic [ADDR_W-1:0] A_DOUT   = 3'd1;
    localparam logic [ADDR_W-1:0] A_AFSEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SLPVAL = 3'd3;
    localparam logic [ADDR_W-1:0] A_CFG    = 3'd4;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;
    localparam int CFG_MEMF  = 0;
    localparam int CFG_CARDF = 1;
    localparam int ST_HOLD   = 0;
endpackage

// File: rtl/gspc_pin_cell.sv
module gspc_pin_cell #(
    parameter bit IS_MEM    = 1'b0,
    parameter bit IS_CARD   = 1'b0,
    parameter bit IS_STROBE = 1'b0
) (
    input  logic mem_float,
    input  logic card_float,
    input  logic dir,
    input  logic dout,
    input  logic af,
    input  logic alt_oe,
    input  logic alt_out,
    input  logic slp,
    output logic run_oe,
    output logic run_out,
    output logic sl_oe,
    output logic sl_out
);
    logic floating;
    logic strobe_hi;

    always_comb begin
        run_oe    = af ? alt_oe  : dir;
        run_out   = af ? alt_out : dout;
        floating  = (IS_MEM && mem_float) || (IS_CARD && card_float);
        strobe_hi = IS_STROBE && !mem_float;
        if (floating) begin
            sl_oe  = 1'b0;
            sl_out = 1'b0;
        end else if (strobe_hi) begin
            sl_oe  = 1'b1;
            sl_out = 1'b1;
        end else begin
            sl_oe  = dir;
            sl_out = slp;
        end
    end
endmodule

// File: rtl/gspc_rd_mux.sv
module gspc_rd_mux #(
    parameter int NUM_PINS = 16
) (
    input  logic                        rd,
    input  logic [gspc_pkg::ADDR_W-1:0] addr,
    input  logic [NUM_PINS-1:0]         dir,
    input  logic [NUM_PINS-1:0]         dout,
    input  logic [NUM_PINS-1:0]         afsel,
    input  logic [NUM_PINS-1:0]         slpval,
    input  logic [1:0]                  cfg,
    input  logic [2:0]                  status,
    output logic [NUM_PINS-1:0]         rdata
);
    import gspc_pkg::*;

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                A_DIR:    rdata = dir;
                A_DOUT:   rdata = dout;
                A_AFSEL:  rdata = afsel;
                A_SLPVAL: rdata = slpval;
                A_CFG:    rdata[1:0] = cfg;
                A_STATUS: rdata[2:0] = status;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sleep_pad_ctrl.sv
module gpio_sleep_pad_ctrl #(
    parameter int                   NUM_PINS    = 16,
    parameter logic [NUM_PINS-1:0]  MEM_MASK    = 16'h0F00,
    parameter logic [NUM_PINS-1:0]  STROBE_MASK = 16'h0700,
    parameter logic [NUM_PINS-1:0]  CARD_MASK   = 16'hF000,
    parameter logic [NUM_PINS-1:0]  ALT_MASK    = 16'h00F0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sleep_enter,
    input  logic                        sleep_exit,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [gspc_pkg::ADDR_W-1:0] reg_addr,
    input  logic [NUM_PINS-1:0]         reg_wdata,
    output logic [NUM_PINS-1:0]         reg_rdata,
    input  logic [NUM_PINS-1:0]         alt_oe,
    input  logic [NUM_PINS-1:0]         alt_out,
    input  logic [NUM_PINS-1:0]         pad_in,
    output logic [NUM_PINS-1:0]         gpio_in,
    output logic [NUM_PINS-1:0]         pad_oe,
    output logic [NUM_PINS-1:0]         pad_out,
    output logic [NUM_PINS-1:0]         pad_ie,
    output logic [NUM_PINS-1:0]         pad_pu,
    output logic                        asleep
);
    import gspc_pkg::*;

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] dout;
        logic [NUM_PINS-1:0] afsel;
        logic [NUM_PINS-1:0] slpval;
        logic [NUM_PINS-1:0] lat_oe;
        logic [NUM_PINS-1:0] lat_out;
        logic                mem_float;
        logic                card_float;
        logic                hold;
        logic                pu_on;
        logic                asleep;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_PINS-1:0] run_oe, run_out, sl_oe, sl_out;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gspc_pin_cell #(
            .IS_MEM    (MEM_MASK[i]),
            .IS_CARD   (CARD_MASK[i]),
            .IS_STROBE (STROBE_MASK[i])
        ) u_cell (
            .mem_float  (st_q.mem_float),
            .card_float (st_q.card_float),
            .dir        (st_q.dir[i]),
            .dout       (st_q.dout[i]),
            .af         (st_q.afsel[i]),
            .alt_oe     (alt_oe[i]),
            .alt_out    (alt_out[i]),
            .slp        (st_q.slpval[i]),
            .run_oe     (run_oe[i]),
            .run_out    (run_out[i]),
            .sl_oe      (sl_oe[i]),
            .sl_out     (sl_out[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (reg_addr)
                A_DIR:    st_d.dir    = reg_wdata;
                A_DOUT:   st_d.dout   = reg_wdata;
                A_AFSEL:  st_d.afsel  = reg_wdata;
                A_SLPVAL: st_d.slpval = reg_wdata;
                A_CFG: begin
                    st_d.mem_float  = reg_wdata[CFG_MEMF];
                    st_d.card_float = reg_wdata[CFG_CARDF];
                end
                A_STATUS: begin
                    if (reg_wdata[ST_HOLD]) begin
                        st_d.hold  = 1'b0;
                        st_d.pu_on = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (st_q.asleep) begin
            if (sleep_exit) begin
                st_d.asleep = 1'b0;
                st_d.afsel  = st_d.afsel | ALT_MASK;
            end
        end else if (sleep_enter) begin
            st_d.asleep  = 1'b1;
            st_d.hold    = 1'b1;
            st_d.lat_oe  = sl_oe;
            st_d.lat_out = sl_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.afsel      <= ALT_MASK;
            st_q.hold       <= 1'b1;
            st_q.pu_on      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    gspc_rd_mux #(.NUM_PINS(NUM_PINS)) u_rd (
        .rd     (reg_rd),
        .addr   (reg_addr),
        .dir    (st_q.dir),
        .dout   (st_q.dout),
        .afsel  (st_q.afsel),
        .slpval (st_q.slpval),
        .cfg    ({st_q.card_float, st_q.mem_float}),
        .status ({st_q.asleep, st_q.pu_on, st_q.hold}),
        .rdata  (reg_rdata)
    );

    assign pad_oe  = st_q.asleep ? st_q.lat_oe  : run_oe;
    assign pad_out = st_q.asleep ? st_q.lat_out : run_out;
    assign pad_ie  = {NUM_PINS{~st_q.hold}};
    assign pad_pu  = {NUM_PINS{st_q.pu_on}};
    assign gpio_in = pad_in & pad_ie;
    assign asleep  = st_q.asleep;
endmodule

// File: rtl/gspc_chk.sv
module gspc_chk #(
    parameter int                  NUM_PINS = 16,
    parameter logic [NUM_PINS-1:0] MEM_MASK = 16'h0F00,
    parameter logic [NUM_PINS-1:0] ALT_MASK = 16'h00F0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sleep_enter,
    input logic                sleep_exit,
    input logic                asleep,
    input logic                mem_float,
    input logic [NUM_PINS-1:0] alt_oe,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_ie,
    input logic [NUM_PINS-1:0] pad_pu
);
    assert_pu_stays_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu == '0) |=> (pad_pu == '0));

    assert_entry_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_enter && !asleep) |=> (asleep && pad_ie == '0));

    assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && $past(asleep)) |-> ($stable(pad_oe) && $stable(pad_out)));

    assert_mem_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_enter && !asleep && mem_float) |=> ((pad_oe & MEM_MASK) == '0));

    assert_wake_alt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && sleep_exit) |=> (!asleep && ((pad_oe & ALT_MASK) == (alt_oe & ALT_MASK))));
endmodule

bind gpio_sleep_pad_ctrl gspc_chk #(
    .NUM_PINS (NUM_PINS),
    .MEM_MASK (MEM_MASK),
    .ALT_MASK (ALT_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_enter (sleep_enter),
    .sleep_exit  (sleep_exit),
    .asleep      (asleep),
    .mem_float   (st_q.mem_float),
    .alt_oe      (alt_oe),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_ie      (pad_ie),
    .pad_pu      (pad_pu)
);

// File: tb/gpio_sleep_pad_ctrl_tb.sv
module gpio_sleep_pad_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_enter = 1'b0, sleep_exit = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [N-1:0] reg_wdata = '0, alt_oe = '0, alt_out = '0, pad_in = '0;
    logic [N-1:0] reg_rdata, gpio_in, pad_oe, pad_out, pad_ie, pad_pu;
    logic asleep;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_sleep_pad_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alt_oe(alt_oe), .alt_out(alt_out), .pad_in(pad_in),
        .gpio_in(gpio_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_ie(pad_ie),
        .pad_pu(pad_pu), .asleep(asleep)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [N-1:0] exp);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
        reg_rd = 1'b0;
        #1;
        check(req, reg_rdata, '0);
    endtask

    task automatic pulse(input bit enter);
        @(negedge clk);
        if (enter) sleep_enter = 1'b1; else sleep_exit = 1'b1;
        @(negedge clk);
        sleep_enter = 1'b0; sleep_exit = 1'b0;
    endtask

    task automatic t_reset();
        alt_oe = 16'hFFFF; alt_out = 16'hAAAA; pad_in = 16'hFFFF;
        #1;
        check("R1 ie", pad_ie, '0);
        check("R1 pu", pad_pu, 16'hFFFF);
        check("R1 oe", pad_oe, 16'h00F0);
        check("R1 out", pad_out, 16'h00A0);
        check("R11 gated", gpio_in, '0);
        rd_check("R1 R12 status", 3'd5, 16'h0003);
        rd_check("R1 R12 afsel", 3'd2, 16'h00F0);
        rd_check("R1 R12 dir", 3'd0, 16'h0000);
    endtask

    task automatic t_hold_clear();
        wr(3'd5, 16'h0000);
        check("R2 zero write ie", pad_ie, '0);
        check("R2 zero write pu", pad_pu, 16'hFFFF);
        wr(3'd5, 16'h0001);
        check("R2 ie", pad_ie, 16'hFFFF);
        check("R2 pu", pad_pu, '0);
        pad_in = 16'h1234;
        #1;
        check("R11 pass", gpio_in, 16'h1234);
        rd_check("R2 R12 status", 3'd5, 16'h0000);
    endtask

    task automatic t_run();
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'hFF0F);
        wr(3'd1, 16'h5A5A);
        check("R4 gpio oe", pad_oe, 16'hFF0F);
        check("R4 gpio out", pad_out, 16'h5A5A);
        alt_oe = 16'h0001; alt_out = 16'h0001;
        wr(3'd2, 16'h0003);
        check("R4 alt oe", pad_oe, 16'hFF0D);
        check("R4 alt out", pad_out, 16'h5A59);
        alt_oe = 16'h0002;
        #1;
        check("R4 alt follows", pad_oe, 16'hFF0E);
        rd_check("R12 dout", 3'd1, 16'h5A5A);
    endtask

    task automatic t_sleep_ordinary();
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h8013);
        wr(3'd3, 16'hA5C3);
        pulse(1'b1);
        check("R5 R7 oe", pad_oe, 16'h8713);
        check("R5 R7 out", pad_out, 16'hA7C3);
        check("R3 ie", pad_ie, '0);
        check("R3 pu", pad_pu, '0);
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'h0000);
        check("R5 hold oe", pad_oe, 16'h8713);
        check("R5 hold out", pad_out, 16'hA7C3);
        rd_check("R12 status sleep", 3'd5, 16'h0005);
        pulse(1'b1);
        check("R10 reenter ignored", pad_oe, 16'h8713);
        alt_oe = 16'h00FF;
        pulse(1'b0);
        check("R10 R9 oe", pad_oe, 16'h00F0);
        rd_check("R9 afsel", 3'd2, 16'h00F0);
        check("R3 ie after wake", pad_ie, '0);
        wr(3'd5, 16'h0001);
        check("R2 ie after wake", pad_ie, 16'hFFFF);
    endtask

    task automatic t_float();
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd4, 16'h0003);
        pulse(1'b1);
        check("R6 R8 oe", pad_oe, 16'h00FF);
        check("R6 R8 out", pad_out, 16'h00FF);
        pulse(1'b0);
        wr(3'd4, 16'h0001);
        pulse(1'b1);
        check("R6 R8 memf only", pad_oe, 16'hF0FF);
        pulse(1'b0);
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0002);
        rd_check("R12 cfg", 3'd4, 16'h0002);
        pulse(1'b1);
        check("R7 R8 cardf oe", pad_oe, 16'h0700);
        check("R7 R8 cardf out", pad_out, 16'h0FFF);
        pulse(1'b0);
    endtask

    task automatic t_exit_awake();
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h00C3);
        pulse(1'b0);
        check("R10 exit ignored oe", pad_oe, 16'h00C3);
        rd_check("R10 afsel kept", 3'd2, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hold_clear();
        t_run();
        t_sleep_ordinary();
        t_float();
        t_exit_awake();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule